// File: doc/BRIEF.md
# Channel Gain Calibration Sequencer

This block runs the gain calibration for a set of measurement channels. Software writes a 24-bit command word. The top byte carries the opcode. The low bits pick the channels to calibrate, and the bits between them hold system setup flags that the block must not disturb. When the calibration opcode arrives, the block does the following in order:

1. It forces the picked channels' gains to unity.
2. It sums each channel's RMS reading over a programmable number of measurement strobes.
3. For each picked channel it computes a new gain: the channel's target value divided by the average reading. The division runs on a restoring divider that produces one quotient bit per clock.
4. It writes each result back only when that channel had no error.

The gain format is unsigned fixed point with 14 fraction bits, so unity is 0x4000. The outcome is reported inside the command word itself. The opcode byte is cleared, and the select bit of every channel that succeeded is cleared. A channel that failed keeps its select bit set and gets back the gain it held before the command.

The controller is a state machine with these states and transitions:

- S_IDLE waits. It goes to S_UNITY when the stored opcode is the calibration code.
- S_UNITY saves the old gains, forces unity and clears the sums. It always goes to S_ACCUM.
- S_ACCUM counts strobes. It goes to S_PICK on the last strobe.
- S_PICK examines the current channel. It moves to the next channel, or to S_FINISH after the last channel, when the channel is not selected or its sum is zero. Otherwise it starts the divider and goes to S_DIV.
- S_DIV goes to S_STORE when the divider finishes.
- S_STORE writes the gain or restores the old one. It goes back to S_PICK, or to S_FINISH after the last channel.
- S_FINISH clears the opcode byte, pulses the done flag and returns to S_IDLE.

Top module: `gain_cal_seq`

## Requirements
- R1: A command write whose bits 23:16 equal 0xCA starts a calibration. A write with any other value in bits 23:16 is only stored: busy stays low and no gain changes.
- R2: Busy is high from the cycle the calibration opcode is stored until the cycle done pulses. Command writes made while busy is high leave the command word unchanged.
- R3: Two clock edges after the command write is taken, every selected channel's gain reads 0x4000. Unselected gains keep their value for the whole run.
- R4: The sums cover exactly N rms_valid strobes, where N is cal_cycles sampled at the start. A cal_cycles value of 0 counts as N = 1.
- R5: For a selected channel with strobe sum S and target T, the new gain is floor(T*N*2^14 / S). This is written when it fits in 16 bits.
- R6: A selected channel whose sum S is zero fails.
- R7: A selected channel whose quotient is 2^16 or more fails.
- R8: A failed channel's gain returns to its value from before the command, and its select bit stays set.
- R9: When the run finishes, done is high for exactly one cycle. In that cycle bits 23:16 read zero, the select bits of channels that succeeded read zero, and bits 15:4 hold their written value.
- R10: Command bit i (for i = 0 to 3) selects channel i. Channel i takes target and RMS from slice i of target_flat and rms_flat, and drives slice i of gain_flat. Each slice is 16 bits and starts at bit 16*i.
- R11: After reset, every gain reads 0x4000, the command word reads 0, and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 24 | Command write value |
| cmd_q | output | 24 | Current command word, including status bits |
| target_flat | input | NCH*DW | Per-channel target values |
| cal_cycles | input | CW | Number of measurement strobes to sum |
| rms_valid | input | 1 | Strobe marking new RMS values |
| rms_flat | input | NCH*DW | Per-channel RMS readings |
| gain_flat | output | NCH*GW | Per-channel gain registers |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The unity gains are due two edges after the command write is taken. The bench reads them four negedges later, while the machine is still waiting for strobes. A write blocked by busy can be seen on cmd_q at the negedge after it is made.

The final gains and the command status settle on the same edge that raises done. The bench therefore polls done at each negedge, with a bounded timeout, and compares everything in that cycle. One negedge later it confirms that done and busy have both dropped. The divider takes a fixed number of cycles for each channel that is selected and has a non-zero sum. Waiting on done keeps the checks correct whatever mix of skipped and divided channels a run has.

// File: rtl/gcal_pkg.sv
package gcal_pkg;
    localparam logic [7:0] CAL_OPCODE = 8'hCA;

    typedef enum logic [2:0] {
        S_IDLE,
        S_UNITY,
        S_ACCUM,
        S_PICK,
        S_DIV,
        S_STORE,
        S_FINISH
    } cal_state_t;
endpackage

// File: rtl/cal_accum.sv
module cal_accum #(
    parameter int NCH = 4,
    parameter int DW  = 16,
    parameter int AW  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [NCH*DW-1:0] sample_flat,
    output logic [NCH*AW-1:0] sum_flat
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [AW-1:0] sum_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sum_q <= '0;
            end else if (clr) begin
                sum_q <= '0;
            end else if (en) begin
                sum_q <= sum_q + {{(AW-DW){1'b0}}, sample_flat[i*DW +: DW]};
            end
        end

        assign sum_flat[i*AW +: AW] = sum_q;
    end
endmodule

// File: rtl/cal_divider.sv
module cal_divider #(
    parameter int NW  = 38,
    parameter int DVW = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [NW-1:0]  dividend,
    input  logic [DVW-1:0] divisor,
    output logic           done,
    output logic [NW-1:0]  quotient
);
    localparam int CNTW = $clog2(NW + 1);

    logic [DVW-1:0]  rem_q;
    logic [NW-1:0]   quo_q;
    logic [CNTW-1:0] cnt_q;
    logic            run_q;
    logic            done_q;
    logic [DVW:0]    shifted;
    logic [DVW:0]    diff;
    logic            ge;

    always_comb begin
        shifted = {rem_q, quo_q[NW-1]};
        ge      = shifted >= {1'b0, divisor};
        diff    = shifted - {1'b0, divisor};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                rem_q <= '0;
                quo_q <= dividend;
                cnt_q <= CNTW'(NW);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= ge ? diff[DVW-1:0] : shifted[DVW-1:0];
                quo_q <= {quo_q[NW-2:0], ge};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNTW'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done     = done_q;
    assign quotient = quo_q;

    // R6
    nonzero_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> divisor != '0);

    // R5
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> rem_q < divisor);
endmodule

// File: rtl/gain_cal_seq.sv
module gain_cal_seq #(
    parameter int NCH  = 4,
    parameter int DW   = 16,
    parameter int GW   = 16,
    parameter int FRAC = 14,
    parameter int CW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [23:0]       cmd_wdata,
    output logic [23:0]       cmd_q,
    input  logic [NCH*DW-1:0] target_flat,
    input  logic [CW-1:0]     cal_cycles,
    input  logic              rms_valid,
    input  logic [NCH*DW-1:0] rms_flat,
    output logic [NCH*GW-1:0] gain_flat,
    output logic              busy,
    output logic              done
);
    import gcal_pkg::*;

    localparam int AW  = DW + CW;
    localparam int NW  = AW + FRAC;
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [GW-1:0] UNITY = GW'(1) << FRAC;

    cal_state_t state, nstate;

    logic [23:0]     cmd_r;
    logic [GW-1:0]   gain_q [NCH];
    logic [GW-1:0]   prev_q [NCH];
    logic [CW-1:0]   ncyc_q;
    logic [CW-1:0]   cyc_cnt;
    logic [CHW-1:0]  ch_q;
    logic            done_q;

    logic [NCH-1:0]    sel;
    logic [NCH*AW-1:0] sum_flat;
    logic [AW-1:0]     cur_sum;
    logic [DW-1:0]     cur_tgt;
    logic [AW-1:0]     tgt_x_n;
    logic [NW-1:0]     dividend;
    logic [NW-1:0]     quotient;
    logic              div_done;
    logic              div_start;
    logic              acc_clr;
    logic              acc_en;
    logic              last_ch;
    logic              overflow;
    logic              cur_sel;
    logic              cur_zero;

    always_comb begin
        sel       = cmd_r[NCH-1:0];
        cur_sum   = sum_flat[ch_q*AW +: AW];
        cur_tgt   = target_flat[ch_q*DW +: DW];
        tgt_x_n   = {{CW{1'b0}}, cur_tgt} * {{DW{1'b0}}, ncyc_q};
        dividend  = {tgt_x_n, {FRAC{1'b0}}};
        last_ch   = ch_q == CHW'(NCH - 1);
        overflow  = |quotient[NW-1:GW];
        cur_sel   = sel[ch_q];
        cur_zero  = cur_sum == '0;
        div_start = (state == S_PICK) && cur_sel && !cur_zero;
        acc_clr   = state == S_UNITY;
        acc_en    = (state == S_ACCUM) && rms_valid;
        busy      = (state != S_IDLE) || (cmd_r[23:16] == CAL_OPCODE);
    end

    cal_accum #(.NCH(NCH), .DW(DW), .AW(AW)) i_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (acc_clr),
        .en          (acc_en),
        .sample_flat (rms_flat),
        .sum_flat    (sum_flat)
    );

    cal_divider #(.NW(NW), .DVW(AW)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (dividend),
        .divisor  (cur_sum),
        .done     (div_done),
        .quotient (quotient)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:   if (cmd_r[23:16] == CAL_OPCODE) nstate = S_UNITY;
            S_UNITY:  nstate = S_ACCUM;
            S_ACCUM:  if (rms_valid && (cyc_cnt == ncyc_q - CW'(1))) nstate = S_PICK;
            S_PICK: begin
                if (cur_sel && !cur_zero) nstate = S_DIV;
                else if (last_ch)         nstate = S_FINISH;
            end
            S_DIV:    if (div_done) nstate = S_STORE;
            S_STORE:  nstate = last_ch ? S_FINISH : S_PICK;
            S_FINISH: nstate = S_IDLE;
            default:  nstate = S_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_r   <= '0;
            ncyc_q  <= '0;
            cyc_cnt <= '0;
            ch_q    <= '0;
            done_q  <= 1'b0;
            for (int i = 0; i < NCH; i++) begin
                gain_q[i] <= UNITY;
                prev_q[i] <= UNITY;
            end
        end else begin
            done_q <= 1'b0;
            if (cmd_we && !busy) cmd_r <= cmd_wdata;
            unique case (state)
                S_IDLE: ;
                S_UNITY: begin
                    for (int i = 0; i < NCH; i++) begin
                        prev_q[i] <= gain_q[i];
                        if (sel[i]) gain_q[i] <= UNITY;
                    end
                    ncyc_q  <= (cal_cycles == '0) ? CW'(1) : cal_cycles;
                    cyc_cnt <= '0;
                    ch_q    <= '0;
                end
                S_ACCUM: if (rms_valid) cyc_cnt <= cyc_cnt + CW'(1);
                S_PICK: begin
                    if (cur_sel && cur_zero) gain_q[ch_q] <= prev_q[ch_q];
                    if (!(cur_sel && !cur_zero) && !last_ch) ch_q <= ch_q + CHW'(1);
                end
                S_DIV: ;
                S_STORE: begin
                    if (overflow) begin
                        gain_q[ch_q] <= prev_q[ch_q];
                    end else begin
                        gain_q[ch_q] <= quotient[GW-1:0];
                        cmd_r[ch_q]  <= 1'b0;
                    end
                    if (!last_ch) ch_q <= ch_q + CHW'(1);
                end
                S_FINISH: begin
                    cmd_r[23:16] <= 8'h00;
                    done_q       <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign cmd_q = cmd_r;
    assign done  = done_q;
    for (genvar i = 0; i < NCH; i++) begin : g_out
        assign gain_flat[i*GW +: GW] = gain_q[i];

        // R3
        unity_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (state == S_ACCUM && cmd_r[i]) |-> gain_q[i] == UNITY);

        // R8
        fail_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (state == S_STORE && ch_q == CHW'(i) && overflow)
            |=> (cmd_r[i] && gain_q[i] == $past(prev_q[i])));
    end

    // R9
    done_clears_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_r[23:16] == 8'h00);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && busy && state != S_FINISH) |=> $stable(cmd_r[23:NCH]));

    // R4
    cycle_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACCUM) |-> (ncyc_q != '0 && cyc_cnt < ncyc_q));
endmodule

// File: tb/test_gain_cal_seq.sv
module test_gain_cal_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [23:0] cmd_wdata = '0;
    logic [23:0] cmd_q;
    logic [63:0] target_flat = '0;
    logic [7:0]  cal_cycles = '0;
    logic        rms_valid = 1'b0;
    logic [63:0] rms_flat = '0;
    logic [63:0] gain_flat;
    logic        busy;
    logic        done;

    int checks = 0;
    int errors = 0;
    int cyc_total = 0;
    longint tgt [4];
    longint rms_seq [4][4];

    always #5 clk = ~clk;

    gain_cal_seq i_gain_cal_seq (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .cmd_q(cmd_q), .target_flat(target_flat), .cal_cycles(cal_cycles),
        .rms_valid(rms_valid), .rms_flat(rms_flat), .gain_flat(gain_flat),
        .busy(busy), .done(done)
    );

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            errors++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc_total);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic write_cmd(input logic [23:0] v);
        @(negedge clk);
        cmd_we = 1'b1;
        cmd_wdata = v;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    function automatic longint gain_of(input int i);
        return longint'(gain_flat[i*16 +: 16]);
    endfunction

    task automatic run_cal(input logic [3:0] sel, input logic [11:0] setup, input int cyc);
        longint prev [4];
        longint expg [4];
        logic [3:0] failm;
        int n;
        int wait_n;
        logic [23:0] word;
        n = (cyc == 0) ? 1 : cyc;
        for (int i = 0; i < 4; i++) begin
            prev[i] = gain_of(i);
            target_flat[i*16 +: 16] = tgt[i][15:0];
        end
        cal_cycles = 8'(cyc);
        word = {8'hCA, setup, sel};
        write_cmd(word);
        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R2 busy", busy, 1);
        for (int i = 0; i < 4; i++) begin
            // R3 and R10: selected gains at unity, others untouched
            if (sel[i]) check(gain_of(i) == 64'h4000, "R3 unity", gain_of(i), 64'h4000);
            else        check(gain_of(i) == prev[i], "R3 unselected", gain_of(i), prev[i]);
        end
        // R2: write while busy is ignored
        write_cmd(24'h123456);
        check(cmd_q == word, "R2 ignored write", cmd_q, word);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) rms_flat[i*16 +: 16] = rms_seq[k][i][15:0];
            rms_valid = 1'b1;
            @(negedge clk);
            rms_valid = 1'b0;
            rms_flat = 64'hFFFF_FFFF_FFFF_FFFF;
            if (k % 2 == 1) @(negedge clk);
        end
        failm = '0;
        for (int i = 0; i < 4; i++) begin
            longint s;
            longint q;
            s = 0;
            for (int k = 0; k < n; k++) s += rms_seq[k][i];
            expg[i] = prev[i];
            if (sel[i]) begin
                if (s == 0) failm[i] = 1'b1;
                else begin
                    q = (tgt[i] * n * 16384) / s;
                    if (q >= 65536) failm[i] = 1'b1;
                    else expg[i] = q;
                end
            end
        end
        wait_n = 0;
        while (!done && wait_n < 2000) begin
            @(negedge clk);
            wait_n++;
        end
        check(done == 1'b1, "R9 done seen", done, 1);
        check(cmd_q == {8'h00, setup, failm}, "R9 status word", cmd_q, {8'h00, setup, failm});
        for (int i = 0; i < 4; i++) begin
            if (!sel[i])       check(gain_of(i) == expg[i], "R3 unselected kept", gain_of(i), expg[i]);
            else if (failm[i]) check(gain_of(i) == expg[i], "R8 restored", gain_of(i), expg[i]);
            else               check(gain_of(i) == expg[i], "R5 R4 gain", gain_of(i), expg[i]);
        end
        @(negedge clk);
        check(done == 1'b0, "R9 pulse", done, 0);
        check(busy == 1'b0, "R2 idle", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11
        for (int i = 0; i < 4; i++) check(gain_of(i) == 64'h4000, "R11 gain", gain_of(i), 64'h4000);
        check(cmd_q == 24'h0, "R11 cmd", cmd_q, 0);
        check(busy == 1'b0 && done == 1'b0, "R11 flags", {busy, done}, 0);

        // R1: other opcode only stored
        write_cmd(24'h55A00F);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 no start", busy, 0);
        check(cmd_q == 24'h55A00F, "R1 stored", cmd_q, 24'h55A00F);
        for (int i = 0; i < 4; i++) check(gain_of(i) == 64'h4000, "R1 gains", gain_of(i), 64'h4000);

        // Sweep over cycle counts and channel masks (R4, R5, R10)
        for (int cyc = 0; cyc < 4; cyc++) begin
            for (int m = 0; m < 4; m++) begin
                logic [3:0] mask;
                case (m)
                    0: mask = 4'hF;
                    1: mask = 4'h5;
                    2: mask = 4'hA;
                    default: mask = 4'h6;
                endcase
                for (int i = 0; i < 4; i++) begin
                    tgt[i] = 1000 + 3000 * i + 517 * cyc + 211 * m;
                    for (int k = 0; k < 4; k++)
                        rms_seq[k][i] = 2000 + 700 * i + 300 * k + 50 * cyc + 97 * m;
                end
                run_cal(mask, 12'(12'hA5 + cyc * 16 + m), cyc);
            end
        end

        // R6, R7, R8: zero sum on channel 1, overflow on channel 2
        for (int i = 0; i < 4; i++) begin
            tgt[i] = 5000 + 100 * i;
            for (int k = 0; k < 4; k++) rms_seq[k][i] = 4000 + 10 * k;
        end
        tgt[2] = 65535;
        for (int k = 0; k < 4; k++) begin
            rms_seq[k][1] = 0;
            rms_seq[k][2] = 2;
        end
        run_cal(4'hF, 12'h3C3, 2);
        run_cal(4'h6, 12'hFFF, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule